// File: doc/BRIEF.md
# Multiplexed System Bus Master Controller

This controller is the processor-side master of a 64-bit bus on which addresses and data share the same wires. A 9-bit command bus runs beside it and says what the shared bus carries in each cycle. An internal requester hands over one request at a time: a single read or write of 1 to 8 bytes, or a block read or write of four doublewords. The controller drives an address cycle. It then either streams the write data or lets the external agent drive the read data back.

The external agent paces the controller in two ways. It holds off new transactions through two active-low ready lines, one for reads and one for writes. The controller keeps the address driven until it samples the right ready line low. The agent also controls when read data arrives. The outgoing data rate is set per request: either one word every cycle, or one word every other cycle with a filler command in between. Each byte of the shared bus has its own parity bit. Incoming data is checked against that parity. Between transactions an external agent can claim the bus with a request line. The controller answers with a release pulse and keeps its drivers off until the request is withdrawn.

Top module: `sysbus_master`

## Requirements
- R1: While reset is active and just after it, ad_oe and cmd_oe are low, req_ready is high, bus_rel_n is high and rd_valid is low.
- R2: In the cycle after a request is accepted (req_valid and req_ready high at a rising edge), ad_out carries req_addr and cmd_out carries an address command. The command fields are: bit 8 = 0; bits 7:5 = transaction type (000 read, 001 write); bit 4 = block; bit 3 = 0; bits 2:0 = byte count minus one for a single transfer, or 0 for a block.
- R3: The address and address command stay driven, unchanged, until the ready line for that transaction is sampled low at a rising edge. Writes use wr_rdy_n and reads use rd_rdy_n. The other ready line has no effect.
- R4: A write sends 1 data word, or 4 for a block, from wd_data. Each data cycle asserts wd_take and drives cmd_out = {1, last, 0, 000000}, where last is 1 only on the final word.
- R5: When mode_half is high at acceptance, every write data cycle except the last is followed by one filler cycle. A filler cycle has cmd_out = 9'h140 (no-data flag at bit 6), ad_out = 0 and wd_take low. When mode_half is low, the data words are back to back.
- R6: Whenever the buses are driven, adc_out bit i is the even parity of ad_out byte i (bits 8i+7..8i), and cmd_par is the even parity of cmd_out.
- R7: After the read ready line is taken, ad_oe and cmd_oe stay low. Each cycle with cmd_in bit 8 = 1 and bit 6 = 0 is delivered one cycle later on rd_valid, together with rd_data = ad_in, rd_last = cmd_in bit 7 and rd_state = cmd_in bits 4:3. Cycles carrying the no-data flag are ignored. The read ends after 1 word, or 4 for a block.
- R8: rd_perr rises together with rd_valid when any adc_in bit differs from the even parity of its byte of ad_in, and is low otherwise.
- R9: When ext_req_n is low in the idle state, req_ready drops at once and bus_rel_n goes low for exactly one cycle. Both buses stay undriven, and a pending request is not accepted, until ext_req_n has been high at a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_block | input | 1 | 1 = four-doubleword block |
| req_size | input | 3 | Byte count minus one for single transfers |
| req_addr | input | 64 | Transfer address |
| mode_half | input | 1 | Outgoing data every other cycle |
| wd_data | input | 64 | Write data for the current beat |
| wd_take | output | 1 | Current write beat is on the bus |
| rd_valid | output | 1 | Read word available |
| rd_data | output | 64 | Read word |
| rd_last | output | 1 | Last flag of the read word |
| rd_state | output | 2 | Cache state carried with the read word |
| rd_perr | output | 1 | Parity mismatch on the read word |
| ad_out | output | 64 | Shared bus, driven value |
| adc_out | output | 8 | Byte parity, driven value |
| ad_oe | output | 1 | Shared bus driver enable |
| ad_in | input | 64 | Shared bus, received value |
| adc_in | input | 8 | Byte parity, received value |
| cmd_out | output | 9 | Command bus, driven value |
| cmd_par | output | 1 | Command parity |
| cmd_oe | output | 1 | Command bus driver enable |
| cmd_in | input | 9 | Command bus, received value |
| rd_rdy_n | input | 1 | Agent can take a read (active low) |
| wr_rdy_n | input | 1 | Agent can take a write (active low) |
| ext_req_n | input | 1 | External agent requests the bus (active low) |
| bus_rel_n | output | 1 | Bus released pulse (active low) |

## Verification
The hardest case to reach from the ports is a block read in which three things happen in the same transaction. The address is retried while the wrong ready line is already low. Filler cycles sit between the data words. One word arrives with a bad parity bit. The stimulus builds this by holding rd_rdy_n high for two address cycles with wr_rdy_n low. It then plays the agent's side of the bus word by word, puts a no-data command between the words, and flips one parity bit on the third word. A second hard case is a release that arrives while a request is waiting. The bench raises req_valid during the released period and expects no bus activity until the external request goes away.

// File: rtl/sysbus_master.sv
module sysbus_master #(
  parameter int DW        = 64,
  parameter int BLK_BEATS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_block,
  input  logic [2:0]    req_size,
  input  logic [DW-1:0] req_addr,
  input  logic          mode_half,
  input  logic [DW-1:0] wd_data,
  output logic          wd_take,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic [1:0]    rd_state,
  output logic          rd_perr,
  output logic [DW-1:0] ad_out,
  output logic [DW/8-1:0] adc_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  input  logic [DW/8-1:0] adc_in,
  output logic [8:0]    cmd_out,
  output logic          cmd_par,
  output logic          cmd_oe,
  input  logic [8:0]    cmd_in,
  input  logic          rd_rdy_n,
  input  logic          wr_rdy_n,
  input  logic          ext_req_n,
  output logic          bus_rel_n
);
  localparam int NB = DW / 8;
  localparam int BW = (BLK_BEATS > 1) ? $clog2(BLK_BEATS) : 1;
  localparam logic [8:0] CMD_FILL = 9'h140;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WDAT, S_RDAT, S_REL, S_SLV} st_t;

  st_t           st_q;
  logic [DW-1:0] addr_q;
  logic          wr_q, blk_q, half_q, ph_q;
  logic [2:0]    size_q;
  logic [BW-1:0] bcnt_q;

  function automatic logic [NB-1:0] bpar(input logic [DW-1:0] d);
    for (int i = 0; i < NB; i++) bpar[i] = ^d[8*i +: 8];
  endfunction

  logic sel_rdy_n, last_beat, data_cyc, in_data;
  assign sel_rdy_n = wr_q ? wr_rdy_n : rd_rdy_n;
  assign last_beat = blk_q ? (bcnt_q == BW'(BLK_BEATS - 1)) : (bcnt_q == '0);
  assign data_cyc  = (st_q == S_WDAT) && !ph_q;
  assign in_data   = cmd_in[8] && !cmd_in[6];

  assign req_ready = (st_q == S_IDLE) && ext_req_n;
  assign bus_rel_n = (st_q != S_REL);
  assign ad_oe     = (st_q == S_ADDR) || (st_q == S_WDAT);
  assign cmd_oe    = ad_oe;
  assign wd_take   = data_cyc;

  always_comb begin
    ad_out  = '0;
    cmd_out = '0;
    if (st_q == S_ADDR) begin
      ad_out  = addr_q;
      cmd_out = {1'b0, 2'b00, wr_q, blk_q, 1'b0, blk_q ? 3'd0 : size_q};
    end else if (st_q == S_WDAT) begin
      if (data_cyc) begin
        ad_out  = wd_data;
        cmd_out = {1'b1, last_beat, 7'd0};
      end else begin
        cmd_out = CMD_FILL;
      end
    end
  end

  assign adc_out = bpar(ad_out);
  assign cmd_par = ^cmd_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      wr_q   <= 1'b0;
      blk_q  <= 1'b0;
      half_q <= 1'b0;
      ph_q   <= 1'b0;
      size_q <= '0;
      bcnt_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (!ext_req_n) begin
            st_q <= S_REL;
          end else if (req_valid) begin
            st_q   <= S_ADDR;
            addr_q <= req_addr;
            wr_q   <= req_write;
            blk_q  <= req_block;
            size_q <= req_size;
            half_q <= mode_half;
            ph_q   <= 1'b0;
            bcnt_q <= '0;
          end
        end
        S_ADDR: if (!sel_rdy_n) st_q <= wr_q ? S_WDAT : S_RDAT;
        S_WDAT: begin
          if (ph_q) begin
            ph_q <= 1'b0;
          end else if (last_beat) begin
            st_q <= S_IDLE;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
            ph_q   <= half_q;
          end
        end
        S_RDAT: begin
          if (in_data) begin
            bcnt_q <= bcnt_q + 1'b1;
            if (last_beat) st_q <= S_IDLE;
          end
        end
        S_REL: st_q <= S_SLV;
        S_SLV: if (ext_req_n) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_last  <= 1'b0;
      rd_state <= '0;
      rd_perr  <= 1'b0;
    end else begin
      rd_valid <= (st_q == S_RDAT) && in_data;
      if ((st_q == S_RDAT) && in_data) begin
        rd_data  <= ad_in;
        rd_last  <= cmd_in[7];
        rd_state <= cmd_in[4:3];
        rd_perr  <= (bpar(ad_in) != adc_in);
      end
    end
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ADDR && sel_rdy_n) |=> (st_q == S_ADDR && $stable(ad_out) && $stable(cmd_out)));

  // R4
  beat_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_take |-> (ad_oe && cmd_out[8] && !cmd_out[6]));

  // R5
  half_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_take && half_q && !last_beat) |=> (!wd_take && cmd_out == CMD_FILL));

  // R9
  rel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rel_n |=> (bus_rel_n && !ad_oe && !cmd_oe));

  // R9
  rel_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rel_n) |-> $past(!ext_req_n));
endmodule

// File: tb/tb_sysbus_master.sv
module tb_sysbus_master;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_block = 1'b0, mode_half = 1'b0;
  logic [2:0] req_size = '0;
  logic [63:0] req_addr = '0, ad_in = '0;
  logic [7:0] adc_in = '0;
  logic [8:0] cmd_in = '0;
  logic rd_rdy_n = 1'b1, wr_rdy_n = 1'b1, ext_req_n = 1'b1;
  logic req_ready, wd_take, rd_valid, rd_last, rd_perr, ad_oe, cmd_par, cmd_oe, bus_rel_n;
  logic [63:0] wd_data, rd_data, ad_out;
  logic [1:0] rd_state;
  logic [7:0] adc_out;
  logic [8:0] cmd_out;

  int nchk = 0, nerr = 0;
  logic [72:0] bus_q[$];
  string bus_tag[$];
  logic [67:0] rd_q[$];
  string rd_tag[$];
  logic [63:0] wbuf[16];
  logic [3:0] wb_idx = '0;
  logic [3:0] wq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysbus_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_block(req_block), .req_size(req_size), .req_addr(req_addr),
    .mode_half(mode_half), .wd_data(wd_data), .wd_take(wd_take), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_last(rd_last), .rd_state(rd_state), .rd_perr(rd_perr),
    .ad_out(ad_out), .adc_out(adc_out), .ad_oe(ad_oe), .ad_in(ad_in), .adc_in(adc_in),
    .cmd_out(cmd_out), .cmd_par(cmd_par), .cmd_oe(cmd_oe), .cmd_in(cmd_in),
    .rd_rdy_n(rd_rdy_n), .wr_rdy_n(wr_rdy_n), .ext_req_n(ext_req_n), .bus_rel_n(bus_rel_n)
  );

  assign wd_data = wbuf[wb_idx];
  always @(posedge clk) if (wd_take) wb_idx <= wb_idx + 4'd1;

  function automatic logic [7:0] bpar(input logic [63:0] d);
    for (int i = 0; i < 8; i++) bpar[i] = ^d[8*i +: 8];
  endfunction

  function automatic logic [8:0] acmd(input logic wr, input logic blk, input logic [2:0] sz);
    acmd = {1'b0, 2'b00, wr, blk, 1'b0, blk ? 3'd0 : sz};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [72:0] act, input logic [72:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (cmd_oe || ad_oe) begin
      // R6 byte and command parity
      chk(adc_out == bpar(ad_out) && cmd_par == ^cmd_out, "R6 parity",
          {56'd0, cmd_par, adc_out, cmd_out}, {56'd0, ^cmd_out, bpar(ad_out), cmd_out});
      if (bus_q.size() == 0) begin
        chk(1'b0, "R7/R9 unexpected bus drive", {ad_out, cmd_out}, '0);
      end else begin
        logic [72:0] e;
        string t;
        e = bus_q.pop_front();
        t = bus_tag.pop_front();
        chk({ad_out, cmd_out} == e, t, {ad_out, cmd_out}, e);
      end
    end
    if (rd_valid) begin
      if (rd_q.size() == 0) begin
        chk(1'b0, "R7 unexpected read word", {5'd0, rd_data, rd_last, rd_state, rd_perr}, '0);
      end else begin
        logic [67:0] e;
        string t;
        e = rd_q.pop_front();
        t = rd_tag.pop_front();
        chk({rd_data, rd_last, rd_state, rd_perr} == e, t,
            {5'd0, rd_data, rd_last, rd_state, rd_perr}, {5'd0, e});
      end
    end
  end

  task automatic wait_done(input string tag);
    while (!req_ready) begin @(posedge clk); #1; end
    repeat (2) begin @(posedge clk); #1; end
    chk(bus_q.size() == 0 && rd_q.size() == 0, tag,
        73'(bus_q.size() + rd_q.size()), '0);
  endtask

  task automatic do_write(input logic [63:0] a, input logic [2:0] sz, input logic blk,
                          input logic half, input int retries);
    int nb;
    nb = blk ? 4 : 1;
    for (int r = 0; r <= retries; r++) begin
      bus_q.push_back({a, acmd(1'b1, blk, sz)});
      bus_tag.push_back(r == 0 ? "R2 write address" : "R3 write retry hold");
    end
    for (int k = 0; k < nb; k++) begin
      logic [63:0] d;
      d = a ^ (64'h1111_2222_3333_4444 * (k + 1));
      wbuf[wq + 4'(k)] = d;
      bus_q.push_back({d, 1'b1, (k == nb - 1), 7'd0});
      bus_tag.push_back("R4 write beat");
      if (half && k < nb - 1) begin
        bus_q.push_back({64'd0, 9'h140});
        bus_tag.push_back("R5 filler cycle");
      end
    end
    wq = wq + 4'(nb);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = 1'b1; req_block = blk; req_size = sz;
    req_addr = a; mode_half = half; wr_rdy_n = 1'b1; rd_rdy_n = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b0; mode_half = 1'b0;
    repeat (retries) begin @(posedge clk); #1; end
    wr_rdy_n = 1'b0; rd_rdy_n = 1'b1;
    @(posedge clk); #1;
    wr_rdy_n = 1'b1;
    wait_done("R4 write complete");
  endtask

  task automatic do_read(input logic [63:0] a, input logic [2:0] sz, input logic blk,
                         input int retries, input int bad);
    int nb;
    nb = blk ? 4 : 1;
    for (int r = 0; r <= retries; r++) begin
      bus_q.push_back({a, acmd(1'b0, blk, sz)});
      bus_tag.push_back(r == 0 ? "R2 read address" : "R3 read retry hold");
    end
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = 1'b0; req_block = blk; req_size = sz;
    req_addr = a; rd_rdy_n = 1'b1; wr_rdy_n = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (retries) begin @(posedge clk); #1; end
    rd_rdy_n = 1'b0; wr_rdy_n = 1'b1;
    @(posedge clk); #1;
    rd_rdy_n = 1'b1;
    for (int k = 0; k < nb; k++) begin
      logic [63:0] d;
      logic lst;
      d = ~a + 64'(k * 7919);
      lst = (k == nb - 1);
      rd_q.push_back({d, lst, 2'(k), (k == bad)});
      rd_tag.push_back(k == bad ? "R8 parity error flag" : "R7 read word");
      ad_in = d;
      adc_in = bpar(d) ^ ((k == bad) ? 8'h04 : 8'h00);
      cmd_in = {1'b1, lst, 1'b0, 1'b0, 2'(k), 3'd0};
      @(posedge clk); #1;
      if (!lst) begin
        ad_in = 64'hDEAD_BEEF_0BAD_F00D;
        adc_in = 8'h5A;
        cmd_in = 9'h140;
        @(posedge clk); #1;
      end
    end
    cmd_in = '0; ad_in = '0; adc_in = '0;
    wait_done("R7 read complete");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 outputs under reset
    chk(!ad_oe && !cmd_oe && req_ready && bus_rel_n && !rd_valid, "R1 reset state",
        {68'd0, ad_oe, cmd_oe, req_ready, bus_rel_n, rd_valid}, 73'b00110);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ad_oe && !cmd_oe && req_ready && bus_rel_n && !rd_valid, "R1 after reset",
        {68'd0, ad_oe, cmd_oe, req_ready, bus_rel_n, rd_valid}, 73'b00110);

    do_write(64'h0000_0000_1234_5678, 3'd3, 1'b0, 1'b0, 0);
    do_write(64'h0000_00AB_CDEF_0007, 3'd7, 1'b0, 1'b0, 2);
    do_write(64'h0000_0040_0000_0000, 3'd0, 1'b1, 1'b0, 1);
    do_write(64'h0000_0080_0000_0020, 3'd5, 1'b1, 1'b1, 0);
    do_write(64'h0000_0000_0000_0F01, 3'd0, 1'b0, 1'b1, 0);
    do_read (64'h0000_0000_00C0_FFEE, 3'd1, 1'b0, 0, -1);
    do_read (64'h0000_0123_4567_89A0, 3'd0, 1'b1, 2, 2);

    // R9 release handshake with a pending request
    @(posedge clk); #1;
    ext_req_n = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 64'hFFFF; req_block = 1'b0;
    @(negedge clk);
    chk(!req_ready, "R9 ready drops", {72'd0, req_ready}, '0);
    @(negedge clk);
    chk(!bus_rel_n && !ad_oe, "R9 release pulse", {71'd0, bus_rel_n, ad_oe}, '0);
    @(negedge clk);
    chk(bus_rel_n, "R9 single-cycle release", {72'd0, bus_rel_n}, 73'd1);
    repeat (3) begin
      @(negedge clk);
      chk(!req_ready && !ad_oe && !cmd_oe, "R9 stays released",
          {70'd0, req_ready, ad_oe, cmd_oe}, '0);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    ext_req_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R9 still slave one cycle", {72'd0, req_ready}, '0);
    @(negedge clk);
    chk(req_ready && bus_rel_n, "R9 bus resumed", {71'd0, req_ready, bus_rel_n}, 73'b11);

    do_write(64'h0000_0200_0000_0000, 3'd2, 1'b1, 1'b0, 0);

    summary();
    $finish;
  end
endmodule